// File: doc/BRIEF.md
# Reference-Clock Elapsed Time Base

This block runs off a fixed 25 MHz reference clock and keeps two free-running, read-only counts for a register bank. The first count is whole seconds elapsed since power-on reset. The second count is reference cycles elapsed within the current second. The register bank samples both outputs directly; nothing can write or preload them.

The sub-second count does not move on every reference cycle. It moves once per 16-cycle slot (640 ns) and adds 16 each time, so its four low bits always read zero. When the next step would reach 25,000,000, the count goes to zero instead, and the seconds count advances on that same edge. The seconds count wraps modulo 2^32.

Power-on reset is the only zero reference: a synchronous, active-high reset clears both counts and the slot prescaler. The cycles per second, the step size and both output widths are parameters. This lets a bench shrink the second without changing the update rules.

Top module: `refclk_time_base`

## Requirements
- R1: While `rst_por` is high at a clock edge, both `ticks_o` and `seconds_o` are zero after that edge.
- R2: The low `STEP_LOG2` bits of `ticks_o` (four bits by default) read zero at all times.
- R3: `ticks_o` advances by 2^`STEP_LOG2` (16 by default) exactly once per 2^`STEP_LOG2` reference cycles. The first advance lands on the 16th rising edge after reset is released.
- R4: `ticks_o` never shows a value at or above `TICKS_PER_SEC`. A step that would reach `TICKS_PER_SEC` loads zero instead.
- R5: `seconds_o` increments by one on the same edge where `ticks_o` wraps to zero, and on no other edge.
- R6: `seconds_o` wraps from its all-ones value to zero, without saturating.
- R7: On edges that are not slot boundaries, both outputs hold their previous values.
- R8: Asserting reset in the middle of a run restarts both counts from zero. The next advance comes a full 16 cycles after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | 25 MHz reference clock |
| rst_por | input | 1 | Synchronous active-high power-on reset |
| seconds_o | output | SEC_W (32) | Whole seconds since the last reset |
| ticks_o | output | SUB_W (32) | Reference cycles within the current second, in steps of 16 |

## Verification
The seconds-count rollover is hard to reach from the ports. At default sizes it needs 2^32 seconds of reference cycles, and no input can preload the count. The bench instead builds the block with a 160-cycle second and a 4-bit seconds output. It then runs straight through sixteen full seconds, checking every cycle, so the wrap from 15 to 0 and every sub-second wrap are crossed in place. After that, resets of random length land at random points, including inside a slot, to show the zero reference restarting.

// File: rtl/refclk_time_pkg.sv
package refclk_time_pkg;

    // Per-edge advance event passed from the slot logic to the counters.
    typedef struct packed {
        logic step;   // a slot boundary: sub-second count moves
        logic wrap;   // the move rolls the sub-second count to zero
    } tb_event_t;

    // Number of step units in one second.
    function automatic int units_per_sec(input int ticks_per_sec, input int step_log2);
        return ticks_per_sec >> step_log2;
    endfunction

    // True when the ticks-per-second figure is a whole number of steps.
    function automatic bit step_aligned(input int ticks_per_sec, input int step_log2);
        return ((ticks_per_sec >> step_log2) << step_log2) == ticks_per_sec;
    endfunction

endpackage

// File: rtl/refclk_slot_prescaler.sv
module refclk_slot_prescaler #(
    parameter int STEP_LOG2 = 4
) (
    input  logic clk,
    input  logic rst,
    output logic slot_o
);
    generate
        if (STEP_LOG2 == 0) begin : g_every_cycle
            assign slot_o = 1'b1;
        end else begin : g_divided
            localparam int PW = STEP_LOG2;
            localparam logic [PW-1:0] LAST = {PW{1'b1}};
            logic [PW-1:0] phase_q;

            always_ff @(posedge clk) begin
                if (rst) phase_q <= '0;
                else     phase_q <= phase_q + PW'(1);
            end

            assign slot_o = (phase_q == LAST);

            AST_SLOT_SPACING: assert property (@(posedge clk) disable iff (rst)
                slot_o |=> !slot_o); // R3
        end
    endgenerate
endmodule

// File: rtl/refclk_subsec_counter.sv
module refclk_subsec_counter
    import refclk_time_pkg::*;
#(
    parameter int TICKS_PER_SEC = 25_000_000,
    parameter int STEP_LOG2     = 4,
    parameter int SUB_W         = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             slot_i,
    output tb_event_t        evt_o,
    output logic [SUB_W-1:0] ticks_o
);
    localparam int UW     = SUB_W - STEP_LOG2;
    localparam int UNITS  = units_per_sec(TICKS_PER_SEC, STEP_LOG2);
    localparam logic [UW-1:0] LAST_U = UW'(UNITS - 1);
    localparam logic [SUB_W-1:0] LIMIT = SUB_W'(TICKS_PER_SEC);

    logic [UW-1:0] unit_q;

    assign evt_o.step = slot_i;
    assign evt_o.wrap = slot_i && (unit_q == LAST_U);

    always_ff @(posedge clk) begin
        if (rst)              unit_q <= '0;
        else if (evt_o.wrap)  unit_q <= '0;
        else if (evt_o.step)  unit_q <= unit_q + UW'(1);
    end

    generate
        if (STEP_LOG2 == 0) begin : g_full
            assign ticks_o = unit_q;
        end else begin : g_scaled
            assign ticks_o = {unit_q, {STEP_LOG2{1'b0}}};
        end
    endgenerate

    AST_BELOW_LIMIT: assert property (@(posedge clk) disable iff (rst)
        ticks_o < LIMIT); // R4
    AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (rst)
        evt_o.wrap |=> (ticks_o == '0)); // R4
    AST_STEP_SIZE: assert property (@(posedge clk) disable iff (rst)
        (evt_o.step && !evt_o.wrap) |=> (ticks_o == $past(ticks_o) + SUB_W'(1 << STEP_LOG2))); // R3
    AST_TICKS_HOLD: assert property (@(posedge clk) disable iff (rst)
        !evt_o.step |=> $stable(ticks_o)); // R7

    initial begin
        AST_CFG_ALIGNED: assert (step_aligned(TICKS_PER_SEC, STEP_LOG2)); // R4
    end
endmodule

// File: rtl/refclk_seconds_counter.sv
module refclk_seconds_counter #(
    parameter int SEC_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc_i,
    output logic [SEC_W-1:0] seconds_o
);
    logic [SEC_W-1:0] sec_q;

    always_ff @(posedge clk) begin
        if (rst)        sec_q <= '0;
        else if (inc_i) sec_q <= sec_q + SEC_W'(1);
    end

    assign seconds_o = sec_q;

    AST_SEC_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        inc_i |=> (seconds_o == $past(seconds_o) + SEC_W'(1))); // R5
    AST_SEC_ROLLOVER: assert property (@(posedge clk) disable iff (rst)
        (inc_i && (&seconds_o)) |=> (seconds_o == '0)); // R6
    AST_SEC_HOLD: assert property (@(posedge clk) disable iff (rst)
        !inc_i |=> $stable(seconds_o)); // R7
endmodule

// File: rtl/refclk_time_base.sv
module refclk_time_base
    import refclk_time_pkg::*;
#(
    parameter int TICKS_PER_SEC = 25_000_000,
    parameter int STEP_LOG2     = 4,
    parameter int SUB_W         = 32,
    parameter int SEC_W         = 32
) (
    input  logic             clk_ref,
    input  logic             rst_por,
    output logic [SEC_W-1:0] seconds_o,
    output logic [SUB_W-1:0] ticks_o
);
    logic      slot;
    tb_event_t evt;

    refclk_slot_prescaler #(.STEP_LOG2(STEP_LOG2)) u_pre (
        .clk    (clk_ref),
        .rst    (rst_por),
        .slot_o (slot)
    );

    refclk_subsec_counter #(
        .TICKS_PER_SEC (TICKS_PER_SEC),
        .STEP_LOG2     (STEP_LOG2),
        .SUB_W         (SUB_W)
    ) u_sub (
        .clk     (clk_ref),
        .rst     (rst_por),
        .slot_i  (slot),
        .evt_o   (evt),
        .ticks_o (ticks_o)
    );

    refclk_seconds_counter #(.SEC_W(SEC_W)) u_sec (
        .clk       (clk_ref),
        .rst       (rst_por),
        .inc_i     (evt.wrap),
        .seconds_o (seconds_o)
    );

    AST_RESET_CLEARS: assert property (@(posedge clk_ref)
        rst_por |=> (ticks_o == '0 && seconds_o == '0)); // R1
    AST_SEC_WITH_WRAP: assert property (@(posedge clk_ref) disable iff (rst_por)
        (seconds_o != $past(seconds_o)) |-> (ticks_o == '0)); // R5
endmodule

// File: tb/refclk_time_base_bench.sv
module refclk_time_base_bench;
    localparam int T_SEC = 160;
    localparam int SL    = 4;
    localparam int SUBW  = 32;
    localparam int SECW  = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [SECW-1:0] seconds;
    logic [SUBW-1:0] ticks;
    longint n = 0;          // edges since reset release
    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    refclk_time_base #(
        .TICKS_PER_SEC (T_SEC),
        .STEP_LOG2     (SL),
        .SUB_W         (SUBW),
        .SEC_W         (SECW)
    ) u_refclk_time_base (
        .clk_ref   (clk),
        .rst_por   (rst),
        .seconds_o (seconds),
        .ticks_o   (ticks)
    );

    always @(posedge clk) begin
        if (rst) n <= 0;
        else     n <= n + 1;
    end

    function automatic longint exp_total(input longint edges);
        return (edges >> SL) << SL;
    endfunction
    function automatic longint exp_ticks(input longint edges);
        return exp_total(edges) % T_SEC;
    endfunction
    function automatic longint exp_secs(input longint edges);
        return (exp_total(edges) / T_SEC) % (1 << SECW);
    endfunction

    task automatic check(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d (n=%0d)", tag, act, exp, n);
        end
    endtask

    // Check outputs at a falling edge, tagging by situation.
    task automatic check_now(input bit after_reset);
        longint es = exp_ticks(n);
        longint ec = exp_secs(n);
        check("R2", ticks[SL-1:0], 0);
        if (rst || n == 0) begin
            check("R1", ticks, 0);
            check("R1", seconds, 0);
        end else if (after_reset && n <= 16) begin
            check("R8", ticks, es);
            check("R8", seconds, ec);
        end else if (n % 16 != 0) begin
            check("R7", ticks, es);
            check("R7", seconds, ec);
        end else if (es == 0) begin
            check("R4", ticks, es);
            if (ec == 0) check("R6", seconds, ec);
            else         check("R5", seconds, ec);
        end else begin
            check("R3", ticks, es);
            check("R5", seconds, ec);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240917));
        repeat (3) @(negedge clk);
        check_now(1'b0);                      // R1 during reset
        rst = 1'b0;
        // Directed: sixteen full seconds, every cycle, crossing R4/R5/R6.
        for (int i = 0; i < 16 * T_SEC + 40; i++) begin
            @(negedge clk);
            check_now(1'b0);
        end
        // Random segments with occasional mid-run resets (R8).
        for (int k = 0; k < 60; k++) begin
            bit did_rst = 1'b0;
            if ($urandom % 4 == 0) begin
                int hold = 1 + int'($urandom % 3);
                rst = 1'b1;
                for (int h = 0; h < hold; h++) begin
                    @(negedge clk);
                    check_now(1'b0);
                end
                rst = 1'b0;
                did_rst = 1'b1;
            end
            begin
                int len = 1 + int'($urandom % 400);
                for (int j = 0; j < len; j++) begin
                    @(negedge clk);
                    check_now(did_rst);
                end
            end
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule